// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This block monitors sixteen synchronised I/O lines, presented as two 8-bit ports, and raises a single shared interrupt when an eligible line toggles in either direction. Lines are gathered into two enable groups. A group whose enable is low cannot set the flag at all. The flag is not merely held back from the request line, so turning a group on later never exposes an event that happened while it was off. Some lines of port A belong to no group and never take part.

Each line also has its own exclusion bit. The bit is already the OR of whatever peripheral conditions claim that line, and a set bit removes the line from change detection. The unit looks only at line values, so a line driven as an output by the chip still triggers it. An edge that also reaches another interrupt source still sets this flag. The flag is sticky until a one-cycle clear, and the request output is the flag qualified by a global enable.

Top module: `pin_change_irq`

## Requirements
- R1: A rising or a falling transition on an eligible line sets `flag_o` at the second rising clock edge after the new value is presented. A change seen at that edge is judged against the group enables and exclusion bits present at that edge.
- R2: Group 1 (`grp_en_i[1]`) covers port B bits 7..4 and port A bits 7, 6 and 3.
- R3: Group 0 (`grp_en_i[0]`) covers port B bits 3..0. Port A bits 0, 1, 2, 4 and 5 never set the flag, whatever the enables are.
- R4: A change on a line whose group enable is low leaves `flag_o` low. Raising the enable afterwards does not set it.
- R5: A change on a line whose `alt_mask_i` bit is set (bit i for port B bit i, bit 8+i for port A bit i) leaves `flag_o` low. Clearing that bit afterwards does not set it.
- R6: `flag_o` stays set until `flag_clr_i` is high at a clock edge. A qualifying change at the same edge as a clear leaves the flag set.
- R7: `irq_o` equals `flag_o` AND `gie_i` at all times.
- R8: After reset `flag_o` is low. Line values present during and right after reset release produce no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_a_i | input | 8 | Synchronised port A line values |
| port_b_i | input | 8 | Synchronised port B line values |
| grp_en_i | input | 2 | Group enables: bit 0 group 0, bit 1 group 1 |
| alt_mask_i | input | 16 | Per-line exclusion; [7:0] port B, [15:8] port A |
| gie_i | input | 1 | Global interrupt enable |
| flag_clr_i | input | 1 | Clears the flag at the clock edge |
| flag_o | output | 1 | Sticky pin-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A line change takes two register stages before it reaches the flag. One stage captures the value and the next compares it with the previous one, so `flag_o` rises at the second edge after the change. `irq_o` follows `gie_i` within the same cycle. The bench drives inputs just after each falling edge. A reference model advances on every rising edge using the inputs present there. Flag and request are compared at each falling edge, so the two-edge latency, the clear-versus-set priority and the combinational request are all checked in the cycle they fall due.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned LINE_W = 2 * PORT_W;
  localparam int unsigned GRP_N  = 2;
  // line index: [7:0] port B, [15:8] port A
  localparam logic [LINE_W-1:0] GRP0_MAP = 16'h000F;
  localparam logic [LINE_W-1:0] GRP1_MAP = 16'hC8F0;
endpackage

// File: rtl/pcint_sampler.sv
module pcint_sampler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lines_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] cur_q, prev_q;
  logic [1:0]   seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
      seen_q <= '0;
    end else begin
      cur_q  <= lines_i;
      prev_q <= cur_q;   // updated even while masked
      seen_q <= {seen_q[0], 1'b1};
    end
  end

  // compare only once both registers hold real samples
  assign chg_o = (cur_q ^ prev_q) & {W{seen_q[1]}};
endmodule

// File: rtl/pcint_gate.sv
module pcint_gate
  import pcint_pkg::*;
(
  input  logic [LINE_W-1:0] chg_i,
  input  logic [GRP_N-1:0]  grp_en_i,
  input  logic [LINE_W-1:0] alt_mask_i,
  output logic [LINE_W-1:0] hit_o
);
  for (genvar i = 0; i < LINE_W; i++) begin : g_line
    logic in_grp;
    assign in_grp   = (GRP0_MAP[i] & grp_en_i[0]) | (GRP1_MAP[i] & grp_en_i[1]);
    assign hit_o[i] = chg_i[i] & in_grp & ~alt_mask_i[i];
  end
endmodule

// File: rtl/pcint_flag.sv
module pcint_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcint_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_a_i,
  input  logic [PORT_W-1:0] port_b_i,
  input  logic [GRP_N-1:0]  grp_en_i,
  input  logic [LINE_W-1:0] alt_mask_i,
  input  logic              gie_i,
  input  logic              flag_clr_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic [LINE_W-1:0] chg, hit;

  pcint_sampler #(.W(LINE_W)) u_sampler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i ({port_a_i, port_b_i}),
    .chg_o   (chg)
  );

  pcint_gate u_gate (
    .chg_i      (chg),
    .grp_en_i   (grp_en_i),
    .alt_mask_i (alt_mask_i),
    .hit_o      (hit)
  );

  pcint_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (|hit),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  assign irq_o = flag_o & gie_i;
endmodule

// File: rtl/pin_change_irq_checker.sv
module pin_change_irq_checker
  import pcint_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINE_W-1:0] chg,
  input logic [LINE_W-1:0] hit,
  input logic [LINE_W-1:0] alt_mask_i,
  input logic              flag_clr_i,
  input logic              gie_i,
  input logic              flag_o,
  input logic              irq_o
);
  assert_hit_sets_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |=> flag_o);
  assert_hit_needs_change_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit & ~chg) == '0));
  assert_never_lines_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit & ~(GRP0_MAP | GRP1_MAP)) == '0));
  assert_masked_line_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit & alt_mask_i) == '0));
  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  assert_clear_works_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !(|hit)) |=> !flag_o);
  assert_no_spurious_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !(|hit)) |=> !flag_o);
  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_i || !flag_o) |-> !irq_o);
endmodule

bind pin_change_irq pin_change_irq_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chg        (chg),
  .hit        (hit),
  .alt_mask_i (alt_mask_i),
  .flag_clr_i (flag_clr_i),
  .gie_i      (gie_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/pin_change_irq_test.sv
module pin_change_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pa = '0, pb = '0;
  logic [1:0]  gen = '0;
  logic [15:0] amask = '0;
  logic        gie = 1'b0, clr = 1'b0;
  logic        flag, irq;

  int checks = 0, fails = 0;
  string phase = "R8";

  localparam logic [15:0] G0 = 16'h000F;
  localparam logic [15:0] G1 = 16'hC8F0;

  always #2.5 clk = ~clk;

  pin_change_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .port_a_i(pa), .port_b_i(pb),
    .grp_en_i(gen), .alt_mask_i(amask), .gie_i(gie), .flag_clr_i(clr),
    .flag_o(flag), .irq_o(irq)
  );

  // reference model
  logic [15:0] m_cur, m_prev;
  int          m_edges;
  logic        m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = '0; m_prev = '0; m_edges = 0; m_flag = 1'b0;
    end else begin
      logic [15:0] elig;
      logic        set;
      elig = ((gen[0] ? G0 : 16'h0) | (gen[1] ? G1 : 16'h0)) & ~amask;
      set  = (m_edges >= 2) && (((m_cur ^ m_prev) & elig) != 0);
      if (set)      m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      m_prev = m_cur;
      m_cur  = {pa, pb};
      if (m_edges < 2) m_edges++;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (flag !== m_flag) begin
      fails++;
      $display("FAIL %s flag_o: actual %b expected %b at %0t", phase, flag, m_flag, $time);
    end
    checks++;
    if (irq !== (m_flag & gie)) begin
      fails++;
      $display("FAIL R7 (%s) irq_o: actual %b expected %b at %0t", phase, irq, m_flag & gie, $time);
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic flip(input int idx);
    logic [15:0] v;
    v = {pa, pb};
    v[idx] = ~v[idx];
    {pa, pb} = v;
    step(4);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; step(1); clr = 1'b0; step(1);
  endtask

  initial begin
    // R8: nonzero lines through reset
    pb = 8'hA5; pa = 8'h48; gen = 2'b11; gie = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(6);

    // R1/R3: group 0, rising then falling on port B bit 0
    phase = "R1";
    pb = 8'h00; step(4); pulse_clr();
    flip(0); pulse_clr();
    flip(0); pulse_clr();

    // R2: each group 1 line, group 1 only
    phase = "R2"; gen = 2'b10; step(2);
    foreach (G1[i]) if (G1[i]) begin flip(i); pulse_clr(); end
    // group 0 lines silent while only group 1 enabled
    phase = "R4";
    for (int i = 0; i < 4; i++) flip(i);

    // R3: group 0 lines with group 0; excluded port A lines never count
    phase = "R3"; gen = 2'b01; step(2);
    for (int i = 0; i < 4; i++) begin flip(i); pulse_clr(); end
    gen = 2'b11; step(2);
    flip(8); flip(9); flip(10); flip(12); flip(13);

    // R4: disabled group, then enable: no stale event
    phase = "R4"; gen = 2'b00; step(2);
    flip(3); flip(15);
    gen = 2'b11; step(6);
    flip(3); pulse_clr();

    // R5: excluded line, then unmask: no false event
    phase = "R5";
    amask = 16'h0020; step(2);
    flip(5); flip(5); flip(5);
    amask = 16'h0000; step(6);
    amask = 16'h0800; step(1);
    flip(11);
    flip(4); pulse_clr();
    amask = '0; step(4);

    // R6: set and clear at the same edge, stickiness
    phase = "R6";
    flip(6); step(8);
    pulse_clr(); step(2);
    {pa, pb} = {pa, pb} ^ 16'h0002; step(1);
    clr = 1'b1; step(1); clr = 1'b0; step(3);
    pulse_clr(); step(2);

    // R7: global enable gating
    phase = "R7";
    flip(2); gie = 1'b0; step(3); gie = 1'b1; step(2); gie = 1'b0; step(1);
    pulse_clr(); gie = 1'b1; step(2);

    // R1: several lines at once
    phase = "R1";
    {pa, pb} = {pa, pb} ^ 16'hC8FF; step(4); pulse_clr(); step(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule